// File: doc/BRIEF.md
# Status Report Frame Generator

This block turns one snapshot of board health readings into a complete Ethernet frame, without preamble, SFD or CRC, and emits it as a byte stream. A single-cycle `trigger` pulse latches a 10-bit temperature reading, eight 12-bit ADC channel readings, a location stamp byte and both MAC addresses. The block then sends the frame one byte per accepted beat on a valid/ready stream and marks the final byte with `m_tlast`.

The frame begins with the destination MAC address, then the source MAC address, then a 16-bit payload length. The payload opens with the location stamp and the status identifier 0x53 ('S'). Next comes an 18-byte sensor block: the temperature word, then the ADC channel words from channel 7 down to channel 0. The sensor block is sent a second time with the same contents so that the payload approaches the Ethernet minimum. Zero bytes complete the payload to 47 bytes. A trigger that arrives while a frame is being sent is dropped.

Top module: `status_frame_gen`

## Requirements
- R1: Frame bytes 0..5 carry `dst_mac` and bytes 6..11 carry `src_mac`, each most significant byte first (`mac[47:40]` first).
- R2: Frame bytes 12 and 13 hold the payload length 47 as a big-endian value: 0x00, then 0x2F.
- R3: Payload byte 0 (frame byte 14) is the latched `location`. Payload byte 1 (frame byte 15) is 0x53.
- R4: Payload bytes 2 and 3 are the temperature as {6'b0, temp[9:8]}, then temp[7:0].
- R5: Payload bytes 4..19 are the ADC words for channels 7, 6, ..., 0 in that order. Each word is sent as {4'b0, adc[11:8]}, then adc[7:0]. Channel k occupies `adc[12k+11:12k]`.
- R6: Payload bytes 20..37 repeat payload bytes 2..19 exactly.
- R7: Payload bytes 38..46 are 0x00. A frame is exactly 61 bytes long. `m_tlast` is high on byte 60 only. `m_tvalid` drops after byte 60 is accepted.
- R8: All readings, the location and the MAC addresses are latched in the trigger cycle. Later changes on those inputs do not alter a frame in progress.
- R9: A trigger while a frame is in progress is ignored. It neither restarts nor extends the frame, and it queues no second frame. With no trigger the stream stays idle.
- R10: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values into the next cycle.
- R11: After reset `m_tvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trigger | input | 1 | Start a frame when idle |
| location | input | 8 | Location stamp byte |
| dst_mac | input | 48 | Destination MAC address |
| src_mac | input | 48 | Source MAC address |
| temp | input | 10 | Temperature reading |
| adc | input | 96 | Eight 12-bit ADC readings, channel k at bits 12k+11:12k |
| m_tdata | output | 8 | Stream byte |
| m_tvalid | output | 1 | Stream byte valid |
| m_tready | input | 1 | Downstream accepts byte |
| m_tlast | output | 1 | Last byte of frame |

## Verification
A byte counter that is wrong by one position would put a wrong field value on the stream at once. The fault would show either as a misplaced 0x53 or length byte, or as `m_tlast` arriving on the wrong beat, in the same frame. A capture register that reloads mid-frame would only show when the inputs change after the trigger, so the bench changes them on purpose. A busy flag that does not hold would show as a restarted header or as an extra unrequested frame after the trigger that fired mid-frame. The bench throttles `m_tready` so that any slip in the hold behaviour shows on the next beat.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam logic [7:0] STATUS_ID = 8'h53;
  localparam int HDR_BYTES = 14;

  function automatic logic [7:0] word_hi(input logic [15:0] w);
    return w[15:8];
  endfunction

  function automatic logic [7:0] word_lo(input logic [15:0] w);
    return w[7:0];
  endfunction
endpackage

// File: rtl/sfg_capture.sv
module sfg_capture #(
  parameter int TEMP_W = 10,
  parameter int ADC_W  = 12,
  parameter int N_ADC  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [7:0]             loc_in,
  input  logic [47:0]            dst_in,
  input  logic [47:0]            src_in,
  input  logic [TEMP_W-1:0]      temp_in,
  input  logic [N_ADC*ADC_W-1:0] adc_in,
  output logic [7:0]             loc_q,
  output logic [47:0]            dst_q,
  output logic [47:0]            src_q,
  output logic [TEMP_W-1:0]      temp_q,
  output logic [N_ADC*ADC_W-1:0] adc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      loc_q  <= '0;
      dst_q  <= '0;
      src_q  <= '0;
      temp_q <= '0;
      adc_q  <= '0;
    end else if (load) begin
      loc_q  <= loc_in;
      dst_q  <= dst_in;
      src_q  <= src_in;
      temp_q <= temp_in;
      adc_q  <= adc_in;
    end
  end
endmodule

// File: rtl/sfg_seq.sv
module sfg_seq #(
  parameter int FRAME_LEN = 61,
  localparam int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigger,
  input  logic             tready,
  output logic             tvalid,
  output logic             tlast,
  output logic [IDX_W-1:0] idx,
  output logic             frame_start,
  output logic             beat_fire,
  output logic             frame_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic busy;

  assign frame_start = !busy && trigger;
  assign beat_fire   = busy && tready;
  assign frame_done  = beat_fire && (idx == LAST_IDX);
  assign tvalid      = busy;
  assign tlast       = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (frame_start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (beat_fire) begin
      if (frame_done) busy <= 1'b0;
      else            idx  <= idx + 1'b1;
    end
  end

  // R11: reset leaves the stream idle
  a_r11_reset_idle: assert property (@(posedge clk) rst |=> !tvalid);
  // R10: a stalled beat is not advanced
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    tvalid && !tready |=> tvalid && $stable(idx));
  // R7: stream drops after the final beat is taken
  a_r7_end_of_frame: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !tvalid);
  // R9: a beat inside a frame never sends the index back to the start
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    beat_fire && !frame_done |=> tvalid && idx != '0);
endmodule

// File: rtl/sfg_byte_mux.sv
module sfg_byte_mux
  import sfg_pkg::*;
#(
  parameter int TEMP_W   = 10,
  parameter int ADC_W    = 12,
  parameter int N_ADC    = 8,
  parameter int PAY_LEN  = 47,
  parameter int REPEATS  = 2,
  parameter int IDX_W    = 6
) (
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             loc_q,
  input  logic [47:0]            dst_q,
  input  logic [47:0]            src_q,
  input  logic [TEMP_W-1:0]      temp_q,
  input  logic [N_ADC*ADC_W-1:0] adc_q,
  output logic [7:0]             byte_out
);
  localparam int BLK_LEN = 2 + 2 * N_ADC;
  localparam logic [15:0] LEN16 = 16'(PAY_LEN);

  function automatic logic [7:0] pick(input int i);
    int p, q, pass, r, ch;
    logic [15:0] w;
    if (i < 6)  return dst_q[8*(5-i) +: 8];
    if (i < 12) return src_q[8*(11-i) +: 8];
    if (i == 12) return word_hi(LEN16);
    if (i == 13) return word_lo(LEN16);
    p = i - HDR_BYTES;
    if (p == 0) return loc_q;
    if (p == 1) return STATUS_ID;
    if (p >= PAY_LEN) return 8'h00;
    q    = p - 2;
    pass = q / BLK_LEN;
    r    = q % BLK_LEN;
    if (pass >= REPEATS) return 8'h00;
    if (r < 2) begin
      w = 16'(temp_q);
    end else begin
      ch = N_ADC - 1 - (r - 2) / 2;
      w  = 16'(adc_q[ch*ADC_W +: ADC_W]);
    end
    return (r % 2 == 0) ? word_hi(w) : word_lo(w);
  endfunction

  always_comb byte_out = pick(int'(idx));
endmodule

// File: rtl/status_frame_gen.sv
module status_frame_gen
  import sfg_pkg::*;
#(
  parameter int TEMP_W  = 10,
  parameter int ADC_W   = 12,
  parameter int N_ADC   = 8,
  parameter int PAY_LEN = 47,
  parameter int REPEATS = 2,
  localparam int FRAME_LEN = HDR_BYTES + PAY_LEN,
  localparam int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   trigger,
  input  logic [7:0]             location,
  input  logic [47:0]            dst_mac,
  input  logic [47:0]            src_mac,
  input  logic [TEMP_W-1:0]      temp,
  input  logic [N_ADC*ADC_W-1:0] adc,
  output logic [7:0]             m_tdata,
  output logic                   m_tvalid,
  input  logic                   m_tready,
  output logic                   m_tlast
);
  logic [IDX_W-1:0]       idx;
  logic                   frame_start, beat_fire, frame_done;
  logic [7:0]             loc_q;
  logic [47:0]            dst_q, src_q;
  logic [TEMP_W-1:0]      temp_q;
  logic [N_ADC*ADC_W-1:0] adc_q;

  sfg_seq #(.FRAME_LEN(FRAME_LEN)) seq_i (
    .clk(clk), .rst(rst), .trigger(trigger), .tready(m_tready),
    .tvalid(m_tvalid), .tlast(m_tlast), .idx(idx),
    .frame_start(frame_start), .beat_fire(beat_fire), .frame_done(frame_done)
  );

  sfg_capture #(.TEMP_W(TEMP_W), .ADC_W(ADC_W), .N_ADC(N_ADC)) cap_i (
    .clk(clk), .rst(rst), .load(frame_start),
    .loc_in(location), .dst_in(dst_mac), .src_in(src_mac),
    .temp_in(temp), .adc_in(adc),
    .loc_q(loc_q), .dst_q(dst_q), .src_q(src_q), .temp_q(temp_q), .adc_q(adc_q)
  );

  sfg_byte_mux #(.TEMP_W(TEMP_W), .ADC_W(ADC_W), .N_ADC(N_ADC),
                 .PAY_LEN(PAY_LEN), .REPEATS(REPEATS), .IDX_W(IDX_W)) mux_i (
    .idx(idx), .loc_q(loc_q), .dst_q(dst_q), .src_q(src_q),
    .temp_q(temp_q), .adc_q(adc_q), .byte_out(m_tdata)
  );

  // R10: stalled byte stays on the bus
  a_r10_data_stable: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> $stable(m_tdata) && $stable(m_tlast));
  // R8: captured readings do not move during a frame
  a_r8_coherent: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && $past(m_tvalid) |-> $stable(temp_q) && $stable(adc_q));
  // R3: identifier byte in its slot
  a_r3_status_id: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && idx == IDX_W'(HDR_BYTES + 1) |-> m_tdata == STATUS_ID);
  // R2: low length byte
  a_r2_length_lo: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && idx == IDX_W'(13) |-> m_tdata == 8'(PAY_LEN));
endmodule

// File: tb/status_frame_gen_tb.sv
module status_frame_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trigger = 1'b0;
  logic [7:0]  location = '0;
  logic [47:0] dst_mac = '0, src_mac = '0;
  logic [9:0]  temp = '0;
  logic [95:0] adc = '0;
  logic [7:0]  m_tdata;
  logic        m_tvalid, m_tlast;
  logic        m_tready = 1'b1;

  int tests = 0, fails = 0;
  bit rnd_ready = 1'b0;
  logic [8:0] q_exp[$];
  string      q_tag[$];
  bit         hold_pend = 1'b0;
  logic [8:0] hold_v;

  always #2 clk = ~clk;

  status_frame_gen dut_i (
    .clk(clk), .rst(rst), .trigger(trigger), .location(location),
    .dst_mac(dst_mac), .src_mac(src_mac), .temp(temp), .adc(adc),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // expected frame built from the requirement text
  task automatic push_frame(input logic [7:0] l, input logic [47:0] d, input logic [47:0] s,
                            input logic [9:0] t, input logic [95:0] a);
    logic [7:0] blk[18];
    logic [7:0] b;
    string tg;
    blk[0] = {6'b0, t[9:8]};
    blk[1] = t[7:0];
    for (int c = 7; c >= 0; c--) begin
      blk[2 + 2*(7-c)] = {4'b0, a[12*c+8 +: 4]};
      blk[3 + 2*(7-c)] = a[12*c +: 8];
    end
    for (int i = 0; i < 61; i++) begin
      if (i < 6)       begin b = d[47-8*i -: 8]; tg = "R1"; end
      else if (i < 12) begin b = s[47-8*(i-6) -: 8]; tg = "R1"; end
      else if (i == 12) begin b = 8'h00; tg = "R2"; end
      else if (i == 13) begin b = 8'h2F; tg = "R2"; end
      else if (i == 14) begin b = l; tg = "R3"; end
      else if (i == 15) begin b = 8'h53; tg = "R3"; end
      else if (i < 34)  begin b = blk[i-16]; tg = (i < 18) ? "R4" : "R5"; end
      else if (i < 52)  begin b = blk[i-34]; tg = "R6"; end
      else              begin b = 8'h00; tg = "R7"; end
      q_exp.push_back({(i == 60), b});
      q_tag.push_back(tg);
    end
  endtask

  task automatic start_frame(input logic [7:0] l, input logic [47:0] d, input logic [47:0] s,
                             input logic [9:0] t, input logic [95:0] a);
    @(negedge clk);
    location = l; dst_mac = d; src_mac = s; temp = t; adc = a;
    trigger = 1'b1;
    push_frame(l, d, s, t, a);
    @(negedge clk);
    trigger = 1'b0;
    // R8: scramble inputs once captured
    location = ~l; dst_mac = ~d; src_mac = ~s; temp = ~t; adc = ~a;
  endtask

  task automatic wait_done();
    while (q_exp.size() != 0) @(negedge clk);
    @(negedge clk);
    check(m_tvalid == 1'b0, "R7 valid after last", m_tvalid, 0);
  endtask

  // ready driver: changes just after each rising edge
  always @(posedge clk) begin
    #1;
    m_tready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        check(m_tvalid && {m_tlast, m_tdata} == hold_v, "R10 stall hold",
              {m_tvalid, m_tlast, m_tdata}, {1'b1, hold_v});
        hold_pend = 1'b0;
      end
      if (m_tvalid && m_tready) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R9 unexpected byte", m_tdata, 0);
        end else begin
          logic [8:0] e;
          string tg;
          e = q_exp.pop_front();
          tg = q_tag.pop_front();
          check(m_tdata == e[7:0], tg, m_tdata, e[7:0]);
          check(m_tlast == e[8], "R7 tlast", m_tlast, e[8]);
        end
      end else if (m_tvalid) begin
        hold_pend = 1'b1;
        hold_v = {m_tlast, m_tdata};
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(m_tvalid == 1'b0, "R11 reset valid", m_tvalid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(m_tvalid == 1'b0, "R11 idle after reset", m_tvalid, 0);

    // frame A, full rate
    start_frame(8'h3C, 48'h0011_2233_4455, 48'hA0B1_C2D3_E4F5, 10'h2A5,
                96'h123_456_789_ABC_DEF_0F1_E2D_3C4);
    wait_done();

    // frame B, throttled, with a trigger mid-frame
    rnd_ready = 1'b1;
    start_frame(8'hE7, 48'hFFEE_DDCC_BBAA, 48'h0102_0304_0506, 10'h0F3,
                96'h800_001_7FF_400_0AA_555_F0F_00F);
    repeat (20) @(negedge clk);
    location = 8'h11; temp = 10'h111; adc = '1;
    trigger = 1'b1;  // R9: must be ignored
    @(negedge clk);
    trigger = 1'b0;
    wait_done();
    repeat (15) @(negedge clk);
    check(m_tvalid == 1'b0, "R9 no queued frame", m_tvalid, 0);

    // frame C, extreme values, throttled
    start_frame(8'hFF, 48'hFFFF_FFFF_FFFF, 48'h0, 10'h3FF, {96{1'b1}});
    wait_done();

    // frame D, zeros, full rate
    rnd_ready = 1'b0;
    start_frame(8'h00, 48'h0, 48'hFFFF_FFFF_FFFF, 10'h000, 96'h0);
    wait_done();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule